// File: doc/BRIEF.md
# Execute Resource Reservation Tracker

This block guards the issue point of an in-order core that feeds two independent back-end pipes. The first is a shared four-stage execute pipe: stage 1 is the shifter or first multiply-accumulate step, stage 2 is the ALU or second step, and stage 3 is saturation or the third step. A writeback stage follows, and ALU and multiply work share all four stages in lockstep. The second is a four-stage memory pipe with address generation, two data-cache stages and its own writeback.

Each cycle the issue logic presents one candidate instruction class. The tracker keeps a per-stage occupancy horizon of future cycles. It raises `stall` in the same cycle when any stage the candidate would need is already booked for the cycle it would need it. When the candidate is free of conflicts it issues, and its reservation pattern is merged into the horizon at the clock edge. The horizon moves one cycle closer every clock. Data dependencies, prediction and cache behaviour are not modelled.

Top module: `exe_reserve_tracker`

## Requirements
- R1: A synchronous active-high `rst` clears every reservation, so `stage_busy` reads all zeros in the cycle after reset and the first request after reset never stalls.
- R2: `stall` is high exactly when `req` is high and the candidate's pattern needs some stage in some future cycle that is already booked. `stall` is combinational on `req` and `op_class`.
- R3: A cycle where `req` is low, or where `stall` is high, books nothing: later `stage_busy` values show only the earlier reservations.
- R4: Class code 0 (branch or call) and the unused codes 9 to 15 need no stage, never stall and book nothing.
- R5: Codes 1 (plain or constant-shift ALU) and 4 (16x16 multiply) book execute stage 1, stage 2, stage 3 and writeback for one cycle each, in the 1st, 2nd, 3rd and 4th cycles after issue.
- R6: Codes 2 (register-shift ALU) and 3 (32-bit multiply or accumulate) book execute stage 1 in cycles 1 and 2 after issue, then stage 2, stage 3 and writeback in cycles 3, 4 and 5.
- R7: Code 5 (long multiply or long accumulate) books execute stage 1 in cycles 1 to 3, stage 2 in cycle 4, stage 3 in cycle 5 and writeback in cycles 6 and 7.
- R8: Code 6 (16x16 multiply with 64-bit accumulate) books execute stage 1 in cycles 1 and 2, stage 2 in cycle 3, stage 3 in cycle 4 and writeback in cycles 5 and 6.
- R9: Code 7 (single or double load/store) books address generation and execute stage 1 together in cycle 1, then data-cache 1, data-cache 2 and memory writeback in cycles 2, 3 and 4.
- R10: Code 8 (load/store of three or four registers) books address generation and execute stage 1 in cycle 1, data-cache 1 in cycles 2 and 3, data-cache 2 in cycle 4 and memory writeback in cycle 5.
- R11: A candidate whose pattern does not overlap the booked horizon issues at once, so disjoint classes, including memory work after execute work, issue back to back.

`stage_busy` bit order: 0 execute stage 1, 1 stage 2, 2 stage 3, 3 execute writeback, 4 address generation, 5 data-cache 1, 6 data-cache 2, 7 memory writeback. Bit s is high when that stage is booked for the current cycle. "Cycle n after issue" is the nth clock cycle after the edge that ends the issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | A candidate instruction is presented this cycle |
| op_class | input | 4 | Class code of the candidate |
| stall | output | 1 | Candidate conflicts and must not issue |
| stage_busy | output | 8 | Per-stage booking for the current cycle |

## Verification
`stall` is due in the same cycle as the candidate, so the bench samples it one time step after driving `req` and `op_class` on the falling edge. A booking made at the edge that ends the issue cycle appears on `stage_busy` from the next falling edge onward, with bit n of a pattern visible n cycles later. The bench therefore compares `stage_busy` on each of the eight falling edges that follow the second candidate against a table-driven union of both patterns. It does this for every ordered pair of classes and every gap of 1 to 7 cycles between them.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int NUM_STAGES = 8;
    localparam int CLASS_W    = 4;

    // stage indices: the order is the stage_busy bit order
    localparam int ST_E1  = 0;
    localparam int ST_E2  = 1;
    localparam int ST_E3  = 2;
    localparam int ST_EWB = 3;
    localparam int ST_LA  = 4;
    localparam int ST_DC1 = 5;
    localparam int ST_DC2 = 6;
    localparam int ST_LWB = 7;

    typedef enum logic [CLASS_W-1:0] {
        CLS_NONE      = 4'd0,
        CLS_ALU       = 4'd1,
        CLS_ALU_RSH   = 4'd2,
        CLS_MUL32     = 4'd3,
        CLS_MUL16     = 4'd4,
        CLS_MUL_LONG  = 4'd5,
        CLS_MAC16_64  = 4'd6,
        CLS_MEM_ONE   = 4'd7,
        CLS_MEM_MULTI = 4'd8
    } op_class_e;
endpackage

// File: rtl/rt_pattern.sv
module rt_pattern
    import rt_pkg::*;
#(
    parameter int HORIZON = 8
) (
    input  logic [CLASS_W-1:0]                   op_class,
    output logic [NUM_STAGES-1:0][HORIZON-1:0]   pat
);
    int  e1_len;
    int  wb_len;
    int  dc1_len;
    logic is_mem;

    always_comb begin
        e1_len  = 0;
        wb_len  = 0;
        dc1_len = 0;
        is_mem  = 1'b0;
        pat     = '0;
        case (op_class)
            CLS_ALU, CLS_MUL16:      begin e1_len = 1; wb_len = 1; end
            CLS_ALU_RSH, CLS_MUL32:  begin e1_len = 2; wb_len = 1; end
            CLS_MUL_LONG:            begin e1_len = 3; wb_len = 2; end
            CLS_MAC16_64:            begin e1_len = 2; wb_len = 2; end
            CLS_MEM_ONE:             begin is_mem = 1'b1; dc1_len = 1; end
            CLS_MEM_MULTI:           begin is_mem = 1'b1; dc1_len = 2; end
            default:                 ;
        endcase
        for (int k = 0; k < HORIZON; k++) begin
            if (e1_len != 0) begin
                pat[ST_E1][k]  = (k < e1_len);
                pat[ST_E2][k]  = (k == e1_len);
                pat[ST_E3][k]  = (k == e1_len + 1);
                pat[ST_EWB][k] = (k >= e1_len + 2) && (k < e1_len + 2 + wb_len);
            end
            if (is_mem) begin
                pat[ST_E1][k]  = (k == 0);
                pat[ST_LA][k]  = (k == 0);
                pat[ST_DC1][k] = (k >= 1) && (k <= dc1_len);
                pat[ST_DC2][k] = (k == dc1_len + 1);
                pat[ST_LWB][k] = (k == dc1_len + 2);
            end
        end
    end
endmodule

// File: rtl/rt_stage_lane.sv
module rt_stage_lane #(
    parameter int HORIZON = 8
) (
    input  logic [HORIZON-1:0] occ,
    input  logic [HORIZON-1:0] need,
    output logic               clash,
    output logic [HORIZON-1:0] aged
);
    // aged[k] is the booking for k cycles after the next edge
    always_comb begin
        aged  = occ >> 1;
        clash = |(need & aged);
    end
endmodule

// File: rtl/exe_reserve_tracker.sv
module exe_reserve_tracker
    import rt_pkg::*;
#(
    parameter int HORIZON = 8   // must cover the longest pattern (7 cycles)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic [CLASS_W-1:0]    op_class,
    output logic                  stall,
    output logic [NUM_STAGES-1:0] stage_busy
);
    typedef struct packed {
        logic [NUM_STAGES-1:0][HORIZON-1:0] occ;
    } trk_state_t;

    trk_state_t state_d, state_q;

    logic [NUM_STAGES-1:0][HORIZON-1:0] need;
    logic [NUM_STAGES-1:0][HORIZON-1:0] aged;
    logic [NUM_STAGES-1:0]              clash;
    logic                               commit;

    rt_pattern #(.HORIZON(HORIZON)) i_pattern (
        .op_class (op_class),
        .pat      (need)
    );

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_lane
        rt_stage_lane #(.HORIZON(HORIZON)) i_lane (
            .occ   (state_q.occ[s]),
            .need  (need[s]),
            .clash (clash[s]),
            .aged  (aged[s])
        );
    end

    always_comb begin
        state_d = state_q;
        stall   = req & (|clash);
        commit  = req & ~(|clash);
        for (int s = 0; s < NUM_STAGES; s++) begin
            state_d.occ[s] = aged[s] | (commit ? need[s] : '0);
            stage_busy[s]  = state_q.occ[s][0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/exe_reserve_tracker_chk.sv
module exe_reserve_tracker_chk
    import rt_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  req,
    input logic [CLASS_W-1:0]    op_class,
    input logic                  stall,
    input logic [NUM_STAGES-1:0] stage_busy
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (stage_busy == '0));

    // R2
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> req);

    // R4
    idle_class_free_chk: assert property (@(posedge clk) disable iff (rst)
        (req && (op_class == 4'd0 || op_class > 4'd8)) |-> !stall);

    // R5
    alu_enters_e1_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !stall && op_class == 4'd1) |=> stage_busy[ST_E1]);

    // R9
    mem_pair_first_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !stall && op_class == 4'd7) |=> (stage_busy[ST_E1] && stage_busy[ST_LA]));

    // R10
    multi_dc1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !stall && op_class == 4'd8) |=> ##1 (stage_busy[ST_DC1] && !stage_busy[ST_LA]));
endmodule

bind exe_reserve_tracker exe_reserve_tracker_chk i_chk (.*);

// File: tb/test_exe_reserve_tracker.sv
module test_exe_reserve_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [3:0] op_class = 4'd0;
    logic       stall;
    logic [7:0] stage_busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exe_reserve_tracker i_exe_reserve_tracker (
        .clk(clk), .rst(rst), .req(req), .op_class(op_class),
        .stall(stall), .stage_busy(stage_busy)
    );

    // offset masks per class and stage, bit n = booked n+1 cycles after issue
    function automatic logic [15:0] mdl(int cls, int st);
        logic [7:0] m [8];
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        case (cls)
            1, 4: begin m[0] = 8'h01; m[1] = 8'h02; m[2] = 8'h04; m[3] = 8'h08; end
            2, 3: begin m[0] = 8'h03; m[1] = 8'h04; m[2] = 8'h08; m[3] = 8'h10; end
            5:    begin m[0] = 8'h07; m[1] = 8'h08; m[2] = 8'h10; m[3] = 8'h60; end
            6:    begin m[0] = 8'h03; m[1] = 8'h04; m[2] = 8'h08; m[3] = 8'h30; end
            7:    begin m[0] = 8'h01; m[4] = 8'h01; m[5] = 8'h02; m[6] = 8'h04; m[7] = 8'h08; end
            8:    begin m[0] = 8'h01; m[4] = 8'h01; m[5] = 8'h06; m[6] = 8'h08; m[7] = 8'h10; end
            default: ;
        endcase
        return {8'h00, m[st]};
    endfunction

    function automatic string tag(int cls);
        case (cls)
            1, 4: return "R5";
            2, 3: return "R6";
            5:    return "R7";
            6:    return "R8";
            7:    return "R9";
            8:    return "R10";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        req = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", stage_busy, 8'h00);
    endtask

    // issue a, wait g cycles, present b, then watch eight cycles
    task automatic scen(int a, int g, int b);
        logic       exp_st;
        logic [7:0] exp_bv;
        do_reset();
        req = 1'b1;
        op_class = 4'(a);
        #1;
        chk("R1", {7'd0, stall}, 8'h00);
        @(negedge clk);
        req = 1'b0;
        repeat (g - 1) @(negedge clk);
        req = 1'b1;
        op_class = 4'(b);
        exp_st = 1'b0;
        for (int s = 0; s < 8; s++)
            if (((mdl(b, s) << g) & mdl(a, s)) != 16'h0) exp_st = 1'b1;
        #1;
        chk(exp_st ? "R2" : "R11", {7'd0, stall}, {7'd0, exp_st});
        @(negedge clk);
        req = 1'b0;
        for (int j = 0; j < 8; j++) begin
            for (int s = 0; s < 8; s++)
                exp_bv[s] = mdl(a, s)[g + j] | (!exp_st & mdl(b, s)[j]);
            chk(exp_st ? "R3" : tag(b), stage_busy, exp_bv);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int g = 1; g < 8; g++)
                    scen(a == 9 ? 13 : a, g, b == 9 ? 12 : b);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            repeat (150000) @(posedge clk);
        join_any
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule